// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the software-facing side of an SMBus host. Its byte-wide register file holds a command byte, a target address with its direction flag, two data bytes and a 32-entry block buffer. Writing the control register with the start bit set launches a transaction. A sequencer then walks the selected protocol (quick, byte, byte-data, word or block) as a series of byte-level operations handed to a bit-level bus engine. Bytes read back land in the data registers or in the block buffer.

The engine side is a pair of valid/ready streams. The request stream carries an operation code (0 start-and-send-address, 1 write byte, 2 read byte, 3 stop) and a byte. The request stays stable while `eng_req_valid` is high and `eng_req_ready` is low. It is taken on the cycle both are high. At most one request is outstanding. `eng_rsp_ready` is high only while the controller waits for the answer to the request it just handed over, and a response is taken on the cycle `eng_rsp_valid` and `eng_rsp_ready` are both high. The response carries the read byte and a NACK flag. The register port has no back-pressure. Read data is combinational, and the side effects of a read take place at the clock edge that ends the read cycle.

Top module: `smb_host_regs`

## Requirements
- R1: Byte offsets are 0 status, 2 control, 3 command, 4 address, 5 data0, 6 data1 and 7 block data. All registers reset to 0. Command, address, data0 and data1 read back what was written. Offset 1 reads 0.
- R2: Reading control returns its stored bits 4:0, with bits 7:5 read as 0. Every read of control resets the block-buffer index to 0.
- R3: Writing control with bit 6 set while idle launches the protocol selected by bits 4:2: 0 quick, 1 byte, 2 byte-data, 3 word, 5 block. A launch sets status bit 0 on the next cycle and clears status bits 1 and 2.
- R4: Quick issues start with the address register unchanged, then stop.
- R5: Byte issues start with the address register unchanged. A read (address bit 0 = 1) then reads one byte into data0. A write then sends the command byte. Stop follows.
- R6: Byte-data issues start with address bit 0 forced to 0, then the command byte. A read follows with a repeated start with bit 0 forced to 1 and one read into data0. A write follows by sending data0. Stop follows.
- R7: Word uses the same prefix as byte-data, then transfers two bytes: low byte in data0 and high byte in data1. A write sends data0 first.
- R8: Block uses the same prefix. A read receives a count into data0, then min(count,32) bytes into buffer entries 0 upward. A write sends data0 as the count, then min(data0,32) bytes from buffer entries 0 upward. A count of 0 goes straight to stop.
- R9: Each read or write of block data accesses the buffer at the current index, then increments the index. After entry 31 the index wraps to 0.
- R10: Status bit 0 is busy. Bit 1 is set when a stop completes without error. Writing 1 to bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged.
- R11: A NACK on a start or write operation skips all remaining operations, issues stop, sets status bit 2 and leaves bit 1 clear. A launch with an unsupported protocol code (4, 6 or 7) sets bit 2 and issues no request.
- R12: While busy, writes to control, command, address, data0, data1 and block data are ignored.
- R13: The engine request stays stable under back-pressure. No new request is issued while a response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at edge) |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| eng_req_valid | output | 1 | Engine request valid |
| eng_req_ready | input | 1 | Engine accepts request |
| eng_req_op | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| eng_req_byte | output | 8 | Address or data byte (0 for read/stop) |
| eng_rsp_valid | input | 1 | Engine response valid |
| eng_rsp_ready | output | 1 | Controller awaits a response |
| eng_rsp_byte | input | 8 | Byte received on a read |
| eng_rsp_nack | input | 1 | Target did not acknowledge |

## Verification
The hardest conditions to reach from the ports are a NACK arriving partway through a protocol, a block count above the buffer size, and register writes that land while a transfer is still running. The target model in the bench NACKs a chosen request number. It returns a count of 40 so that the clamp to 32 is exercised. It also withholds ready on two cycles out of three, which holds a transfer busy long enough for the bench to read busy and to attempt writes into its window. The expected operation stream for every launch comes from a behavioural model and is matched request by request, with back-pressure active for part of the run.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_WRITE = 2'd1,
    BOP_READ  = 2'd2,
    BOP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START1, SQ_CMD, SQ_START2, SQ_COUNT, SQ_DATA, SQ_STOP
  } seq_state_e;

  localparam logic [2:0] PR_QUICK     = 3'd0;
  localparam logic [2:0] PR_BYTE      = 3'd1;
  localparam logic [2:0] PR_BYTE_DATA = 3'd2;
  localparam logic [2:0] PR_WORD      = 3'd3;
  localparam logic [2:0] PR_BLOCK     = 3'd5;

  localparam int OFS_STATUS = 0;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_CMD    = 3;
  localparam int OFS_ADDR   = 4;
  localparam int OFS_DATA0  = 5;
  localparam int OFS_DATA1  = 6;
  localparam int OFS_BLOCK  = 7;

  localparam int ST_BUSY   = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_ERR    = 2;
  localparam int CTL_START = 6;
  localparam int CTL_PLSB  = 2;
  localparam int CTL_KEEP  = 5;
endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [IW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data_a = mem[rd_idx_a];
  assign rd_data_b = mem[rd_idx_b];
endmodule

// File: rtl/smb_seq.sv
module smb_seq import smb_host_pkg::*; #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [2:0]    proto_in,
  input  logic [DW-1:0] addr_b,
  input  logic [DW-1:0] cmd_b,
  input  logic [DW-1:0] d0_b,
  input  logic [DW-1:0] d1_b,
  input  logic [DW-1:0] buf_rd,
  output logic          busy,
  output logic          fin_ok,
  output logic          fin_err,
  output logic          d0_we,
  output logic          d1_we,
  output logic          buf_we,
  output logic [DW-1:0] res,
  output logic [IW-1:0] buf_idx,
  output logic          eng_req_valid,
  input  logic          eng_req_ready,
  output logic [1:0]    eng_req_op,
  output logic [DW-1:0] eng_req_byte,
  input  logic          eng_rsp_valid,
  output logic          eng_rsp_ready,
  input  logic [DW-1:0] eng_rsp_byte,
  input  logic          eng_rsp_nack
);
  localparam int CW = IW + 1;
  localparam logic [DW-1:0] DEPTH_B = DW'(DEPTH);

  seq_state_e    st;
  logic          pend, err_q, rd_q;
  logic [2:0]    pr_q;
  logic [CW-1:0] k_q, n_q;

  logic supported, req_fire, rsp_fire, nackable, rd_ok;
  logic [CW-1:0] fixed_n, clamp_n;
  logic [DW-1:0] cnt_src, data_src;

  assign supported = proto_in inside {PR_QUICK, PR_BYTE, PR_BYTE_DATA, PR_WORD, PR_BLOCK};
  assign eng_req_valid = (st != SQ_IDLE) && !pend;
  assign eng_rsp_ready = pend;
  assign req_fire = eng_req_valid && eng_req_ready;
  assign rsp_fire = eng_rsp_valid && pend;
  assign busy     = (st != SQ_IDLE);

  assign fixed_n = (pr_q == PR_WORD) ? CW'(2) : CW'(1);
  assign cnt_src = rd_q ? eng_rsp_byte : d0_b;
  assign clamp_n = (cnt_src > DEPTH_B) ? CW'(DEPTH) : CW'(cnt_src);

  always_comb begin
    case (pr_q)
      PR_BYTE:      data_src = cmd_b;
      PR_BYTE_DATA: data_src = d0_b;
      PR_WORD:      data_src = (k_q == '0) ? d0_b : d1_b;
      default:      data_src = buf_rd;
    endcase
  end

  always_comb begin
    eng_req_op   = BOP_STOP;
    eng_req_byte = '0;
    case (st)
      SQ_START1: begin
        eng_req_op   = BOP_START;
        eng_req_byte = (pr_q == PR_QUICK || pr_q == PR_BYTE) ? addr_b
                                                             : {addr_b[DW-1:1], 1'b0};
      end
      SQ_CMD: begin
        eng_req_op   = BOP_WRITE;
        eng_req_byte = cmd_b;
      end
      SQ_START2: begin
        eng_req_op   = BOP_START;
        eng_req_byte = {addr_b[DW-1:1], 1'b1};
      end
      SQ_COUNT: begin
        eng_req_op   = rd_q ? BOP_READ : BOP_WRITE;
        eng_req_byte = rd_q ? '0 : d0_b;
      end
      SQ_DATA: begin
        eng_req_op   = rd_q ? BOP_READ : BOP_WRITE;
        eng_req_byte = rd_q ? '0 : data_src;
      end
      default: ;
    endcase
  end

  assign nackable = (st == SQ_START1) || (st == SQ_CMD) || (st == SQ_START2) ||
                    (!rd_q && (st == SQ_COUNT || st == SQ_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      pend  <= 1'b0;
      err_q <= 1'b0;
      rd_q  <= 1'b0;
      pr_q  <= PR_QUICK;
      k_q   <= '0;
      n_q   <= '0;
    end else begin
      if (req_fire) pend <= 1'b1;
      if (st == SQ_IDLE) begin
        if (launch && supported) begin
          st    <= SQ_START1;
          pr_q  <= proto_in;
          rd_q  <= addr_b[0];
          err_q <= 1'b0;
        end
      end else if (rsp_fire) begin
        pend <= 1'b0;
        if (st != SQ_STOP && nackable && eng_rsp_nack) begin
          err_q <= 1'b1;
          st    <= SQ_STOP;
        end else begin
          case (st)
            SQ_START1:
              if (pr_q == PR_QUICK) st <= SQ_STOP;
              else if (pr_q == PR_BYTE) begin
                st <= SQ_DATA; k_q <= '0; n_q <= fixed_n;
              end else st <= SQ_CMD;
            SQ_CMD:
              if (rd_q) st <= SQ_START2;
              else if (pr_q == PR_BLOCK) st <= SQ_COUNT;
              else begin
                st <= SQ_DATA; k_q <= '0; n_q <= fixed_n;
              end
            SQ_START2:
              if (pr_q == PR_BLOCK) st <= SQ_COUNT;
              else begin
                st <= SQ_DATA; k_q <= '0; n_q <= fixed_n;
              end
            SQ_COUNT: begin
              n_q <= clamp_n;
              k_q <= '0;
              st  <= (clamp_n == '0) ? SQ_STOP : SQ_DATA;
            end
            SQ_DATA:
              if (k_q == n_q - CW'(1)) st <= SQ_STOP;
              else k_q <= k_q + CW'(1);
            SQ_STOP: st <= SQ_IDLE;
            default: st <= SQ_IDLE;
          endcase
        end
      end
    end
  end

  assign fin_ok  = rsp_fire && (st == SQ_STOP) && !err_q;
  assign fin_err = (rsp_fire && (st == SQ_STOP) && err_q) ||
                   ((st == SQ_IDLE) && launch && !supported);

  assign rd_ok  = rsp_fire && rd_q;
  assign d0_we  = rd_ok && ((st == SQ_COUNT) ||
                  (st == SQ_DATA && (pr_q == PR_BYTE || pr_q == PR_BYTE_DATA ||
                                     (pr_q == PR_WORD && k_q == '0))));
  assign d1_we  = rd_ok && (st == SQ_DATA) && (pr_q == PR_WORD) && (k_q != '0);
  assign buf_we = rd_ok && (st == SQ_DATA) && (pr_q == PR_BLOCK);
  assign res     = eng_rsp_byte;
  assign buf_idx = k_q[IW-1:0];
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs import smb_host_pkg::*; #(
  parameter int DW        = 8,
  parameter int BUF_DEPTH = 32,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          eng_req_valid,
  input  logic          eng_req_ready,
  output logic [1:0]    eng_req_op,
  output logic [DW-1:0] eng_req_byte,
  input  logic          eng_rsp_valid,
  output logic          eng_rsp_ready,
  input  logic [DW-1:0] eng_rsp_byte,
  input  logic          eng_rsp_nack
);
  localparam int IW = $clog2(BUF_DEPTH);
  localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_CMD    = AW'(OFS_CMD);
  localparam logic [AW-1:0] A_ADDR   = AW'(OFS_ADDR);
  localparam logic [AW-1:0] A_DATA0  = AW'(OFS_DATA0);
  localparam logic [AW-1:0] A_DATA1  = AW'(OFS_DATA1);
  localparam logic [AW-1:0] A_BLOCK  = AW'(OFS_BLOCK);

  logic [CTL_KEEP-1:0] ctrl_q;
  logic [DW-1:0]       cmd_q, addr_q, d0_q, d1_q;
  logic [IW-1:0]       idx_q;
  logic                done_q, err_q;

  logic          seq_busy, fin_ok, fin_err, seq_d0_we, seq_d1_we, seq_buf_we;
  logic [DW-1:0] seq_res, host_buf_rd, seq_buf_rd;
  logic [IW-1:0] seq_idx;
  logic          wr_live, launch;

  assign wr_live = reg_wr && !seq_busy;
  assign launch  = wr_live && (reg_addr == A_CTRL) && reg_wdata[CTL_START];

  smb_seq #(.DW(DW), .DEPTH(BUF_DEPTH), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .proto_in(reg_wdata[CTL_PLSB +: 3]),
    .addr_b(addr_q), .cmd_b(cmd_q), .d0_b(d0_q), .d1_b(d1_q), .buf_rd(seq_buf_rd),
    .busy(seq_busy), .fin_ok(fin_ok), .fin_err(fin_err),
    .d0_we(seq_d0_we), .d1_we(seq_d1_we), .buf_we(seq_buf_we),
    .res(seq_res), .buf_idx(seq_idx),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_req_op(eng_req_op), .eng_req_byte(eng_req_byte),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ready(eng_rsp_ready),
    .eng_rsp_byte(eng_rsp_byte), .eng_rsp_nack(eng_rsp_nack)
  );

  smb_blk_buf #(.DW(DW), .DEPTH(BUF_DEPTH), .IW(IW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seq_busy ? seq_buf_we : (wr_live && reg_addr == A_BLOCK)),
    .wr_idx(seq_busy ? seq_idx : idx_q),
    .wr_data(seq_busy ? seq_res : reg_wdata),
    .rd_idx_a(idx_q), .rd_data_a(host_buf_rd),
    .rd_idx_b(seq_idx), .rd_data_b(seq_buf_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; cmd_q <= '0; addr_q <= '0; d0_q <= '0; d1_q <= '0;
      idx_q  <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_STATUS) begin
        if (reg_wdata[ST_DONE]) done_q <= 1'b0;
        if (reg_wdata[ST_ERR])  err_q  <= 1'b0;
      end
      if (launch) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (fin_ok)  done_q <= 1'b1;
      if (fin_err) err_q  <= 1'b1;
      if (wr_live) begin
        case (reg_addr)
          A_CTRL:  ctrl_q <= reg_wdata[CTL_KEEP-1:0];
          A_CMD:   cmd_q  <= reg_wdata;
          A_ADDR:  addr_q <= reg_wdata;
          A_DATA0: d0_q   <= reg_wdata;
          A_DATA1: d1_q   <= reg_wdata;
          A_BLOCK: idx_q  <= idx_q + IW'(1);
          default: ;
        endcase
      end
      if (reg_rd && reg_addr == A_CTRL)  idx_q <= '0;
      if (reg_rd && reg_addr == A_BLOCK) idx_q <= idx_q + IW'(1);
      if (seq_d0_we) d0_q <= seq_res;
      if (seq_d1_we) d1_q <= seq_res;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: begin
        reg_rdata[ST_BUSY] = seq_busy;
        reg_rdata[ST_DONE] = done_q;
        reg_rdata[ST_ERR]  = err_q;
      end
      A_CTRL:  reg_rdata[CTL_KEEP-1:0] = ctrl_q;
      A_CMD:   reg_rdata = cmd_q;
      A_ADDR:  reg_rdata = addr_q;
      A_DATA0: reg_rdata = d0_q;
      A_DATA1: reg_rdata = d1_q;
      A_BLOCK: reg_rdata = host_buf_rd;
      default: ;
    endcase
  end
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          eng_req_valid,
  input logic          eng_req_ready,
  input logic [1:0]    eng_req_op,
  input logic [DW-1:0] eng_req_byte,
  input logic          eng_rsp_ready,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] cmd_q,
  input logic [IW-1:0] idx_q
);
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req_valid && !eng_req_ready |=>
      eng_req_valid && $stable(eng_req_op) && $stable(eng_req_byte));

  // R13
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_req_valid && eng_rsp_ready));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_req_valid && !eng_rsp_ready);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == AW'(2) && reg_wdata[6] && !busy &&
    (reg_wdata[4:2] inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5}) |=> busy);

  // R2
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == AW'(2) |-> reg_rdata[7:5] == 3'b000);

  // R12
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_addr == AW'(3) |=> $stable(cmd_q));

  // R9
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == AW'(7) && (&idx_q) |=> idx_q == '0);
endmodule

bind smb_host_regs smb_host_regs_chk #(.DW(DW), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req_valid(eng_req_valid),
  .eng_req_ready(eng_req_ready), .eng_req_op(eng_req_op), .eng_req_byte(eng_req_byte),
  .eng_rsp_ready(eng_rsp_ready), .busy(seq_busy), .done(done_q), .cmd_q(cmd_q),
  .idx_q(idx_q)
);

// File: tb/smb_host_regs_tb.sv
module smb_host_regs_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       eng_req_valid, eng_req_ready, eng_rsp_valid, eng_rsp_ready, eng_rsp_nack;
  logic [1:0] eng_req_op;
  logic [7:0] eng_req_byte, eng_rsp_byte;

  smb_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_req_op(eng_req_op), .eng_req_byte(eng_req_byte),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ready(eng_rsp_ready),
    .eng_rsp_byte(eng_rsp_byte), .eng_rsp_nack(eng_rsp_nack)
  );

  int checks = 0, fails = 0;
  int cyc = 0, wd = 0;
  string cur_tag = "R4";
  logic [9:0] exp_q[$];
  logic [7:0] tq[$];
  int  nack_at = -1, req_n = 0, hold_bad = 0;
  bit  stall = 0, rsp_taken = 0, hold_prev = 0;
  logic [9:0] hold_val;
  logic [7:0] m_addr, m_cmd, m_d0, m_d1, e_d0, e_d1;
  logic [7:0] m_buf[32], e_buf[32];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      summary();
    end
  end

  // target model and per-clock comparison against the expected request stream
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      eng_req_ready = stall ? ((cyc % 3) == 0) : 1'b1;
      if (hold_prev && (!eng_req_valid || {eng_req_op, eng_req_byte} != hold_val))
        hold_bad++;
      if (rsp_taken) begin
        eng_rsp_valid = 1'b0; rsp_taken = 0;
      end else if (eng_rsp_valid && eng_rsp_ready) rsp_taken = 1;
      if (eng_req_valid && eng_req_ready) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL %s unexpected request actual=0x%0h expected=none", cur_tag,
                   {eng_req_op, eng_req_byte});
        end else chk(cur_tag, "request", {eng_req_op, eng_req_byte}, exp_q.pop_front());
        eng_rsp_byte = (eng_req_op == 2'd2 && tq.size() > 0) ? tq.pop_front() : 8'h00;
        eng_rsp_nack = (req_n == nack_at);
        req_n++;
        eng_rsp_valid = 1'b1;
      end
      hold_prev = eng_req_valid && !eng_req_ready;
      hold_val  = {eng_req_op, eng_req_byte};
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic setregs(input logic [7:0] a, input logic [7:0] c,
                         input logic [7:0] x0, input logic [7:0] x1);
    wr(3'd4, a); wr(3'd3, c); wr(3'd5, x0); wr(3'd6, x1);
    m_addr = a; m_cmd = c; m_d0 = x0; m_d1 = x1;
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b);
    exp_q.push_back({op, b});
  endtask

  // behavioural model of the operation stream and the resulting registers
  task automatic plan(input int pr, input int nk);
    bit rd_f = m_addr[0];
    int cnt, n;
    exp_q.delete();
    e_d0 = m_d0; e_d1 = m_d1;
    for (int i = 0; i < 32; i++) e_buf[i] = m_buf[i];
    if (!(pr inside {0, 1, 2, 3, 5})) return;
    if (pr <= 1) push(2'd0, m_addr);
    else begin
      push(2'd0, {m_addr[7:1], 1'b0});
      push(2'd1, m_cmd);
      if (rd_f) push(2'd0, {m_addr[7:1], 1'b1});
    end
    case (pr)
      1: if (rd_f) begin push(2'd2, 0); e_d0 = tq[0]; end else push(2'd1, m_cmd);
      2: if (rd_f) begin push(2'd2, 0); e_d0 = tq[0]; end else push(2'd1, m_d0);
      3: if (rd_f) begin
           push(2'd2, 0); push(2'd2, 0); e_d0 = tq[0]; e_d1 = tq[1];
         end else begin push(2'd1, m_d0); push(2'd1, m_d1); end
      5: if (rd_f) begin
           push(2'd2, 0); cnt = tq[0]; e_d0 = tq[0]; n = cnt > 32 ? 32 : cnt;
           for (int i = 0; i < n; i++) begin push(2'd2, 0); e_buf[i] = tq[i+1]; end
         end else begin
           push(2'd1, m_d0); cnt = m_d0; n = cnt > 32 ? 32 : cnt;
           for (int i = 0; i < n; i++) push(2'd1, m_buf[i]);
         end
      default: ;
    endcase
    if (nk >= 0) while (exp_q.size() > nk + 1) void'(exp_q.pop_back());
    push(2'd3, 0);
  endtask

  task automatic launch(input string tag, input int pr, input int nk);
    logic [7:0] cw;
    cur_tag = tag; nack_at = nk; req_n = 0;
    plan(pr, nk);
    cw = 8'h40 | 8'(pr << 2);
    wr(3'd2, cw);
  endtask

  task automatic finish_txn(input string tag, input int exp_sts);
    logic [7:0] s;
    do rd(3'd0, s); while (s[0]);
    chk(tag, "status after transfer", s, exp_sts);
    chk(tag, "expected requests left", exp_q.size(), 0);
    m_d0 = e_d0; m_d1 = e_d1;
    for (int i = 0; i < 32; i++) m_buf[i] = e_buf[i];
  endtask

  task automatic chk_data(input string tag);
    logic [7:0] v;
    rd(3'd5, v); chk(tag, "data0", v, m_d0);
    rd(3'd6, v); chk(tag, "data1", v, m_d1);
  endtask

  task automatic chk_buf(input string tag);
    logic [7:0] v;
    rd(3'd2, v);
    for (int i = 0; i < 32; i++) begin
      rd(3'd7, v); chk(tag, $sformatf("buffer[%0d]", i), v, m_buf[i]);
    end
  endtask

  initial begin
    logic [7:0] v;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    eng_req_ready = 0; eng_rsp_valid = 0; eng_rsp_byte = 0; eng_rsp_nack = 0;
    for (int i = 0; i < 32; i++) m_buf[i] = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1", $sformatf("reset reg %0d", a), v, 0);
    end
    setregs(8'hA4, 8'h3C, 8'h11, 8'h22);
    rd(3'd4, v); chk("R1", "address readback", v, 8'hA4);
    rd(3'd3, v); chk("R1", "command readback", v, 8'h3C);
    chk_data("R1");
    rd(3'd1, v); chk("R1", "offset 1", v, 0);

    // R2 control mask
    wr(3'd2, 8'hBF);
    rd(3'd2, v); chk("R2", "control masked", v, 8'h1F);
    rd(3'd0, v); chk("R2", "no launch without start bit", v, 0);

    // R9 fill, read back, wrap
    for (int i = 0; i < 32; i++) begin
      m_buf[i] = 8'(8'h80 + i * 3); wr(3'd7, m_buf[i]);
    end
    chk_buf("R9");
    rd(3'd7, v); chk("R9", "index wrapped to entry 0", v, m_buf[0]);
    rd(3'd7, v); rd(3'd7, v);
    rd(3'd2, v);
    rd(3'd7, v); chk("R2", "control read resets index", v, m_buf[0]);

    // R4 quick write and read
    launch("R4", 0, -1); finish_txn("R4", 2);
    setregs(8'hA5, 8'h3C, 8'h11, 8'h22);
    launch("R4", 0, -1); finish_txn("R4", 2);

    // R5 byte write and read
    setregs(8'h50, 8'h3C, 8'h11, 8'h22);
    launch("R5", 1, -1); finish_txn("R5", 2); chk_data("R5");
    setregs(8'h51, 8'h3C, 8'h11, 8'h22);
    tq = '{8'h5A};
    launch("R5", 1, -1); finish_txn("R5", 2); chk_data("R5");

    // R6 byte-data
    setregs(8'h60, 8'h07, 8'hC3, 8'h22);
    launch("R6", 2, -1); finish_txn("R6", 2);
    setregs(8'h61, 8'h08, 8'hC3, 8'h22);
    tq = '{8'h9E};
    launch("R6", 2, -1); finish_txn("R6", 2); chk_data("R6");

    // R7 word, with back-pressure on the request stream (R13)
    stall = 1;
    setregs(8'h70, 8'h09, 8'hCD, 8'hAB);
    launch("R7", 3, -1); finish_txn("R7", 2);
    setregs(8'h71, 8'h0A, 8'h00, 8'h00);
    tq = '{8'h34, 8'h12};
    launch("R7", 3, -1); finish_txn("R7", 2); chk_data("R7");
    stall = 0;

    // R8 block write of 3, block read of 4, block read clamped at 32
    setregs(8'h20, 8'h40, 8'd3, 8'h00);
    launch("R8", 5, -1); finish_txn("R8", 2);
    setregs(8'h21, 8'h41, 8'h00, 8'h00);
    tq = '{8'd4, 8'hE1, 8'hE2, 8'hE3, 8'hE4};
    launch("R8", 5, -1); finish_txn("R8", 2); chk_data("R8"); chk_buf("R8");
    tq.delete(); tq.push_back(8'd40);
    for (int i = 0; i < 32; i++) tq.push_back(8'(8'h10 + i));
    launch("R8", 5, -1); finish_txn("R8", 2); chk_data("R8"); chk_buf("R8");
    setregs(8'h20, 8'h42, 8'd0, 8'h00);
    launch("R8", 5, -1); finish_txn("R8", 2);

    // R11 NACK on address, NACK on command, unsupported protocol
    setregs(8'h62, 8'h07, 8'hC3, 8'h00);
    launch("R11", 2, 0); finish_txn("R11", 4);
    launch("R11", 2, 1); finish_txn("R11", 4);
    rd(3'd5, v); chk("R11", "data0 untouched after nack", v, 8'hC3);
    launch("R11", 4, -1); finish_txn("R11", 4);

    // R10 write-one-to-clear
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R10", "write 0 keeps error", v, 4);
    wr(3'd0, 8'h04);
    rd(3'd0, v); chk("R10", "error cleared", v, 0);
    launch("R10", 0, -1); finish_txn("R10", 2);
    wr(3'd0, 8'h02);
    rd(3'd0, v); chk("R10", "done cleared", v, 0);

    // R12 writes while busy are ignored; R3 busy seen after launch
    stall = 1;
    setregs(8'h20, 8'h55, 8'd3, 8'h66);
    launch("R12", 5, -1);
    rd(3'd0, v); chk("R3", "busy after launch", v, 1);
    wr(3'd3, 8'hEE); wr(3'd5, 8'h77); wr(3'd6, 8'h78); wr(3'd4, 8'h99);
    finish_txn("R12", 2);
    stall = 0;
    rd(3'd3, v); chk("R12", "command unchanged", v, 8'h55);
    rd(3'd4, v); chk("R12", "address unchanged", v, 8'h20);
    chk_data("R12");

    chk("R13", "request hold violations", hold_bad, 0);
    summary();
  end
endmodule